// File: doc/BRIEF.md
# Byte FIFO with threshold flags

This block is the byte-wide staging buffer between a host bus and a card data path. The host, or the data path, pushes bytes at one end and pops them at the other in arrival order. A packed status byte reports the state at all times. A control byte sets a threshold level and chooses which threshold condition may raise a request.

The request is a one-cycle event. It feeds the host interrupt status as a FIFO threshold event. For a card write, the request is armed on the drain side so the host refills the buffer when the level runs low. For a card read, it is armed on the fill side so the host empties the buffer when enough bytes have arrived. A threshold of 8 is the usual setting for both directions. A synchronous clear input empties the buffer and keeps the control settings. The block reset clears the control settings as well.

Top module: `byte_fifo_thr`

## Requirements
- R1: After reset the status byte is 0xB0, thr_req is 0, rd_data is 0xFF and the control settings are all zero.
- R2: Bytes leave in the order they were accepted. rd_data shows the popped byte from the clock edge that takes the pop and holds it until the next pop.
- R3: The status bits are: bit 7 empty, bit 6 full, bit 5 empty-threshold flag, bit 4 full-threshold flag, bits 3:0 fill level. The buffer holds 16 bytes. At 16 bytes the level field reads 15 and bit 6 is 1.
- R4: A push while full is ignored. The level stays at full and the stored bytes are unchanged.
- R5: A pop while empty is ignored. The level stays at 0 and rd_data becomes 0xFF.
- R6: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the level unchanged. On an empty buffer, only the push takes effect.
- R7: The control byte bits 3:0 set the threshold T. The empty-threshold flag is 1 when level <= T. The full-threshold flag is 1 when level >= T.
- R8: Control bit 5 arms the request on the empty-threshold flag and bit 4 arms it on the full-threshold flag. thr_req is 1 for one cycle on the edge where an armed flag goes from 0 to 1. Arming a flag that is already 1 counts as such an edge. A flag that stays at 1 raises nothing further.
- R9: After a control write of 0, thr_req stays 0 whatever the level does.
- R10: fifo_clr empties the buffer on the same edge. The status then shows empty with level 0, evaluated against the threshold that is still in force. Bytes pushed afterwards come out with no earlier content mixed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| fifo_clr | input | 1 | Synchronous FIFO clear; control settings are kept |
| push | input | 1 | Push wr_data this cycle |
| wr_data | input | 8 | Byte to push |
| pop | input | 1 | Pop one byte this cycle |
| rd_data | output | 8 | Last popped byte, or 0xFF after a pop on an empty buffer |
| ctl_we | input | 1 | Write the control byte |
| ctl_wdata | input | 8 | Control byte: 3:0 threshold, 4 arm full side, 5 arm empty side |
| status | output | 8 | Packed flags and fill level |
| thr_req | output | 1 | One-cycle threshold request |

## Verification
Every result is due one cycle after its stimulus. A push, pop, clear or control write sampled at an edge updates status, rd_data and thr_req on that same edge. The bench therefore drives inputs on the falling edge and reads all outputs one time unit after the next rising edge. Because thr_req is a pulse, it is checked in the cycle of the crossing and again one idle cycle later, where it must be 0. Each level change is compared against a status byte that the bench computes from its own queue model.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  // status flag offsets above the fill-level field
  localparam int ST_EMPTY = 3;
  localparam int ST_FULL  = 2;
  localparam int ST_ETHR  = 1;
  localparam int ST_FTHR  = 0;
  // control byte arm bits
  localparam int CT_ARM_E = 5;
  localparam int CT_ARM_F = 4;
endpackage

// File: rtl/bfifo_mem.sv
module bfifo_mem #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH),
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          is_empty,
  output logic [CW-1:0] cnt_next
);
  logic [CW-1:0] cnt_q;
  logic          is_full;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CW'(DEPTH));
  assign wr_go    = push & ~is_full & ~clr;
  assign rd_go    = pop & ~is_empty & ~clr;
  assign cnt_next = clr ? '0 : cnt_q + CW'(wr_go) - CW'(rd_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      wr_addr <= '0;
      rd_addr <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (clr) begin
        wr_addr <= '0;
        rd_addr <= '0;
      end else begin
        if (wr_go) wr_addr <= adv(wr_addr);
        if (rd_go) rd_addr <= adv(rd_addr);
      end
    end
  end

  // R4: level never exceeds the depth, and a lone push on a full buffer keeps it full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr && is_full) |=> (cnt_q == CW'(DEPTH)));
  // R5: a lone pop on an empty buffer keeps it empty
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && is_empty) |=> (cnt_q == '0));
  // R10: clear empties the buffer on the same edge
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> is_empty);
endmodule

// File: rtl/bfifo_flags.sv
module bfifo_flags
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH),
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_e,
  input  logic          arm_f,
  input  logic [AW-1:0] level,
  input  logic [CW-1:0] cnt_next,
  output logic [AW+3:0] status,
  output logic          req
);
  logic ef, ff;
  logic armed_e_q, armed_f_q;
  logic [AW-1:0] field;

  assign ef    = (cnt_next <= CW'(level));
  assign ff    = (cnt_next >= CW'(level));
  assign field = (cnt_next >= CW'(DEPTH - 1)) ? AW'(DEPTH - 1) : cnt_next[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      status[AW+ST_EMPTY] <= 1'b1;
      status[AW+ST_ETHR]  <= 1'b1;
      status[AW+ST_FTHR]  <= 1'b1;
      req       <= 1'b0;
      armed_e_q <= 1'b0;
      armed_f_q <= 1'b0;
    end else begin
      status[AW-1:0]      <= field;
      status[AW+ST_EMPTY] <= (cnt_next == '0);
      status[AW+ST_FULL]  <= (cnt_next == CW'(DEPTH));
      status[AW+ST_ETHR]  <= ef;
      status[AW+ST_FTHR]  <= ff;
      req       <= (arm_e & ef & ~armed_e_q) | (arm_f & ff & ~armed_f_q);
      armed_e_q <= arm_e & ef;
      armed_f_q <= arm_f & ff;
    end
  end

  // R8: a request only accompanies an armed, asserted flag
  a_r8_req_armed: assert property (@(posedge clk) disable iff (rst)
    req |-> (armed_e_q | armed_f_q));
  // R3: empty implies a zero level field
  a_r3_empty_level: assert property (@(posedge clk) disable iff (rst)
    status[AW+ST_EMPTY] |-> (status[AW-1:0] == '0));
endmodule

// File: rtl/byte_fifo_thr.sv
module byte_fifo_thr
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_clr,
  input  logic          push,
  input  logic [7:0]    wr_data,
  input  logic          pop,
  output logic [7:0]    rd_data,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [AW+3:0] status,
  output logic          thr_req
);
  logic          wr_go, rd_go, is_empty;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cnt_next;
  logic [7:0]    mem_q;
  logic          rd_blank_q;
  logic [AW-1:0] lvl_q, lvl_n;
  logic          arm_e_q, arm_f_q, arm_e_n, arm_f_n;
  logic          unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wdata[7:6];

  assign lvl_n   = ctl_we ? ctl_wdata[AW-1:0] : lvl_q;
  assign arm_e_n = ctl_we ? ctl_wdata[CT_ARM_E] : arm_e_q;
  assign arm_f_n = ctl_we ? ctl_wdata[CT_ARM_F] : arm_f_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      arm_e_q <= 1'b0;
      arm_f_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_n;
      arm_e_q <= arm_e_n;
      arm_f_q <= arm_f_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || fifo_clr) rd_blank_q <= 1'b1;
    else if (pop)        rd_blank_q <= is_empty;
  end

  assign rd_data = rd_blank_q ? 8'hFF : mem_q;

  bfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(push), .pop(pop),
    .wr_go(wr_go), .wr_addr(wr_addr), .rd_go(rd_go), .rd_addr(rd_addr),
    .is_empty(is_empty), .cnt_next(cnt_next)
  );

  bfifo_mem #(.DW(8), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_go), .raddr(rd_addr), .rdata(mem_q)
  );

  bfifo_flags #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_flags (
    .clk(clk), .rst(rst), .arm_e(arm_e_n), .arm_f(arm_f_n), .level(lvl_n),
    .cnt_next(cnt_next), .status(status), .req(thr_req)
  );

  // R5: a pop on an empty buffer yields 0xFF
  a_r5_empty_pop_ff: assert property (@(posedge clk) disable iff (rst)
    (pop && status[AW+ST_EMPTY] && !fifo_clr) |=> (rd_data == 8'hFF));
  // R3: full reads as a saturated level field
  a_r3_full_saturates: assert property (@(posedge clk) disable iff (rst)
    status[AW+ST_FULL] |-> (status[AW-1:0] == AW'(DEPTH - 1)));
endmodule

// File: tb/byte_fifo_thr_test.sv
`timescale 1ns/1ps
module byte_fifo_thr_test;
  logic clk = 0, rst = 1, fifo_clr = 0, push = 0, pop = 0, ctl_we = 0;
  logic [7:0] wr_data = 0, ctl_wdata = 0;
  logic [7:0] rd_data, status;
  logic thr_req;
  int checks = 0, fails = 0, thr = 0;
  logic [7:0] model[$];
  logic [7:0] exp_rd = 8'hFF;
  bit done = 0;

  always #10 clk = ~clk;

  byte_fifo_thr uut (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .push(push), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .status(status), .thr_req(thr_req)
  );

  function automatic logic [7:0] es(input int c, input int t);
    logic [3:0] f;
    f = (c >= 15) ? 4'd15 : c[3:0];
    return {c == 0, c == 16, c <= t, c >= t, f};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [7:0] d);
    int pre;
    @(negedge clk);
    push = p; pop = q; wr_data = d; ctl_we = 0; fifo_clr = 0;
    @(posedge clk); #1;
    pre = model.size();
    if (q) exp_rd = (pre > 0) ? model.pop_front() : 8'hFF;
    if (p && pre < 16) model.push_back(d);
  endtask

  task automatic idle();
    step(0, 0, 0);
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk);
    push = 0; pop = 0; ctl_we = 1; ctl_wdata = v; fifo_clr = 0;
    @(posedge clk); #1;
    thr = v[3:0];
  endtask

  task automatic clr();
    @(negedge clk);
    push = 0; pop = 0; ctl_we = 0; fifo_clr = 1;
    @(posedge clk); #1;
    model.delete(); exp_rd = 8'hFF;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'hB0);
    chk("R1 thr_req", {7'd0, thr_req}, 8'd0);
    chk("R1 rd_data", rd_data, 8'hFF);
  endtask

  task automatic t_order();
    wctl(8'h08);
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 8'(8'h10 + i * 7));
      chk("R3 status fill", status, es(i + 1, 8));
    end
    chk("R3 full byte", status, 8'h5F);
    step(1, 0, 8'hEE);
    chk("R4 push on full", status, 8'h5F);
    for (int i = 0; i < 16; i++) begin
      step(0, 1, 0);
      chk("R2 order", rd_data, exp_rd);
      chk("R2 status drain", status, es(15 - i, 8));
    end
    chk("R4 last byte not dropped push", rd_data, 8'(8'h10 + 15 * 7));
    step(0, 1, 0);
    chk("R5 pop empty data", rd_data, 8'hFF);
    chk("R5 pop empty status", status, 8'hA0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(1, 0, 8'(8'hA0 + i));
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 8'(8'hB0 + i));
      chk("R6 level held", status, es(3, 8));
      chk("R6 data order", rd_data, exp_rd);
    end
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0);
      chk("R6 drain", rd_data, exp_rd);
    end
    step(1, 1, 8'h77);
    chk("R6 empty push+pop data", rd_data, 8'hFF);
    chk("R6 empty push+pop level", status, es(1, 8));
    step(0, 1, 0);
    chk("R6 pushed byte", rd_data, 8'h77);
  endtask

  task automatic t_thresholds();
    wctl(8'h03);
    chk("R7 level0 thr3", status, es(0, 3));
    for (int i = 1; i <= 5; i++) begin
      step(1, 0, 8'(i));
      chk("R7 flags", status & 8'h30, es(i, 3) & 8'h30);
    end
  endtask

  task automatic t_req_full();
    clr();
    wctl(8'h18);
    chk("R8 no req at arm", {7'd0, thr_req}, 8'd0);
    for (int i = 1; i <= 7; i++) begin
      step(1, 0, 8'(i));
      chk("R8 below thr", {7'd0, thr_req}, 8'd0);
    end
    step(1, 0, 8'h08);
    chk("R8 full-side edge", {7'd0, thr_req}, 8'd1);
    idle();
    chk("R8 one cycle", {7'd0, thr_req}, 8'd0);
    step(1, 0, 8'h09);
    chk("R8 no repeat", {7'd0, thr_req}, 8'd0);
  endtask

  task automatic t_req_empty();
    clr();
    wctl(8'h28);
    chk("R8 arm on set flag", {7'd0, thr_req}, 8'd1);
    idle();
    chk("R8 pulse ends", {7'd0, thr_req}, 8'd0);
    for (int i = 1; i <= 9; i++) begin
      step(1, 0, 8'(i));
      chk("R8 filling", {7'd0, thr_req}, 8'd0);
    end
    step(0, 1, 0);
    chk("R8 drain-side edge", {7'd0, thr_req}, 8'd1);
    idle();
    chk("R8 drain one cycle", {7'd0, thr_req}, 8'd0);
  endtask

  task automatic t_disarm();
    clr();
    wctl(8'h00);
    for (int i = 1; i <= 12; i++) begin
      step(1, 0, 8'(i));
      chk("R9 disarmed fill", {7'd0, thr_req}, 8'd0);
    end
    for (int i = 1; i <= 12; i++) begin
      step(0, 1, 0);
      chk("R9 disarmed drain", {7'd0, thr_req}, 8'd0);
    end
  endtask

  task automatic t_clear();
    wctl(8'h08);
    for (int i = 0; i < 3; i++) step(1, 0, 8'(8'hC0 + i));
    clr();
    chk("R10 cleared status", status, 8'hA0);
    step(1, 0, 8'h5A);
    step(0, 1, 0);
    chk("R10 fresh data", rd_data, 8'h5A);
    chk("R10 empty again", status, 8'hA0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    t_reset();
    t_order();
    t_simul();
    t_thresholds();
    t_req_full();
    t_req_empty();
    t_disarm();
    t_clear();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule